// File: doc/BRIEF.md
# Scanline Shadow Latch and Raster Interrupt Unit

This unit is the per-line timing core of a video display controller. A horizontal dot counter and a vertical line counter mark each frame. The CPU writes a vertical scroll, a horizontal scroll and a control word whenever it likes. The unit copies those values into shadow registers at three fixed points ahead of each line's active window, so the rendering pipeline sees values that do not change for the whole line. The three copies happen on three consecutive clocks: vertical scroll first, then horizontal scroll, then the two layer-enable bits. The first copy happens a fixed lead before the window opens. That lead equals the render pipeline depth plus six clocks.

The unit also raises two interrupts. A raster-compare interrupt fires at the start of the line that comes before the line whose raster number matches a programmed value. A vertical-blank interrupt fires at the start of the first line after the display lines. Each source has its own enable. Any pending flag drives the single IRQ output. A status read returns the flags and clears them. The time from a raster-compare interrupt to the shadow copy for the matching line is fixed, so software knows how many cycles it has to update the scroll values.

Top module: `scanline_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, h_pos and v_pos are 0, all shadow outputs are 0, irq is low and rdata at address 0 is 0.
- R2: h_pos counts from 0 to H_TOTAL-1 and then wraps to 0. v_pos increments at each wrap and wraps from V_TOTAL-1 to 0. disp_active is high exactly when H_DISP_START <= h_pos < H_DISP_START+H_DISP_WIDTH and V_DISP_START <= v_pos < V_DISP_START+V_DISP_LINES.
- R3: vscroll_sh loads the vertical scroll register (address 2, bits 9:0) on the clock edge that ends the cycle with h_pos = H_DISP_START-(PIPE_DEPTH+6). It holds its value at all other times.
- R4: hscroll_sh loads the horizontal scroll register (address 3, bits 9:0) exactly one clock after the vertical copy. It holds its value at all other times.
- R5: bg_en_sh and spr_en_sh load control bits 0 and 1 (address 0 write) exactly one clock after the horizontal copy. They hold their values at all other times.
- R6: A CPU write made in the same cycle as the matching copy strobe is the value that the copy captures.
- R7: Define raster(v) = ((v+1) mod V_TOTAL) - V_DISP_START + 64, taken to 10 bits. When control bit 2 is set, the raster flag sets in the cycle after h_pos = 0 on a line v where raster(v) equals the compare register (address 1).
- R8: When control bit 3 is set, the vertical-blank flag sets in the cycle after h_pos = 0 on line V_DISP_START+V_DISP_LINES.
- R9: A source whose enable bit is clear sets neither its status flag nor irq.
- R10: irq is high exactly when at least one status flag is set.
- R11: rdata at address 0 returns the raster flag in bit 0 and the vertical-blank flag in bit 1, with all other bits 0. A cycle with rd_en high and address 0 clears both flags on the next clock. An event in that same cycle is kept.
- R12: The raster flag becomes visible exactly H_TOTAL + H_DISP_START - (PIPE_DEPTH+6) cycles before vscroll_sh shows the value for the matching line.
- R13: rdata at address 1 returns the compare register, at address 2 the vertical scroll and at address 3 the horizontal scroll, all zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| rd_en | input | 1 | CPU read strobe; a read at address 0 clears the status flags |
| addr | input | 2 | Register select: 0 control/status, 1 compare, 2 vertical scroll, 3 horizontal scroll |
| wdata | input | 16 | CPU write data |
| rdata | output | 16 | CPU read data for the selected register |
| irq | output | 1 | Combined interrupt request |
| h_pos | output | HW | Horizontal dot counter |
| v_pos | output | VW | Vertical line counter |
| disp_active | output | 1 | Inside the active display window |
| vscroll_sh | output | 10 | Vertical scroll value used for the line |
| hscroll_sh | output | 10 | Horizontal scroll value used for the line |
| bg_en_sh | output | 1 | Background enable used for the line |
| spr_en_sh | output | 1 | Sprite enable used for the line |

## Verification
Scroll and control writes are made both away from the copy points and exactly in the cycle of each strobe. This shows whether same-cycle data is forwarded and whether the three copies fall on the right consecutive clocks. The compare register is swept over every line of a small frame, so an off-by-one in the line offset or in the interrupt column moves the observed rise. Runs with each enable pattern, a status read that lands on an event cycle, and a measured gap from interrupt to copy separate enable gating, clear priority and the fixed software timing window. A cycle-level counter model in the bench checks every output on every cycle.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

    localparam int DATA_W      = 16;
    localparam int SCROLL_W    = 10;
    localparam int RASTER_W    = 10;
    localparam int RASTER_BASE = 64;
    localparam int LEAD_EXTRA  = 6;
    localparam int NUM_SRC     = 2;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RASTER  = 2'd1,
        SEL_VSCROLL = 2'd2,
        SEL_HSCROLL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic vbl_irq_en;
        logic ras_irq_en;
        logic spr_en;
        logic bg_en;
    } ctrl_t;

    typedef struct packed {
        logic spr_en;
        logic bg_en;
    } layer_t;

    typedef struct packed {
        logic vbl;
        logic ras;
    } irq_vec_t;

    typedef struct packed {
        logic ctrl;
        logic hscroll;
        logic vscroll;
    } strobe_t;

    function automatic int copy_lead(input int pipe_depth);
        return pipe_depth + LEAD_EXTRA;
    endfunction

endpackage

// File: rtl/scan_counter.sv
module scan_counter
    import scanline_pkg::*;
#(
    parameter int H_TOTAL      = 80,
    parameter int H_DISP_START = 40,
    parameter int H_DISP_WIDTH = 32,
    parameter int V_TOTAL      = 12,
    parameter int V_DISP_START = 2,
    parameter int V_DISP_LINES = 8,
    parameter int PIPE_DEPTH   = 16,
    parameter int HW           = 7,
    parameter int VW           = 4
) (
    input  logic                clk,
    input  logic                rst,
    output logic [HW-1:0]       h_cnt,
    output logic [VW-1:0]       v_cnt,
    output logic                line_start,
    output logic                vbl_line,
    output logic                disp_active,
    output logic [RASTER_W-1:0] ras_next,
    output strobe_t             strobe
);

    localparam int FIRST_COPY = H_DISP_START - copy_lead(PIPE_DEPTH);
    localparam int VBL_ROW    = V_DISP_START + V_DISP_LINES;

    logic          h_last;
    logic          v_last;
    logic [VW-1:0] v_next;
    logic [2:0]    strobe_bits;

    assign h_last = (h_cnt == HW'(H_TOTAL - 1));
    assign v_last = (v_cnt == VW'(V_TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (h_last) begin
            h_cnt <= '0;
            v_cnt <= v_last ? '0 : v_cnt + VW'(1);
        end else begin
            h_cnt <= h_cnt + HW'(1);
        end
    end

    for (genvar gi = 0; gi < 3; gi++) begin : g_strobe
        assign strobe_bits[gi] = (h_cnt == HW'(FIRST_COPY + gi));
    end
    assign strobe = strobe_t'(strobe_bits);

    assign v_next     = v_last ? '0 : v_cnt + VW'(1);
    assign ras_next   = RASTER_W'(v_next) + RASTER_W'(RASTER_BASE) - RASTER_W'(V_DISP_START);
    assign line_start = (h_cnt == '0);
    assign vbl_line   = (v_cnt == VW'(VBL_ROW));

    assign disp_active = (h_cnt >= HW'(H_DISP_START))
                      && (h_cnt <  HW'(H_DISP_START + H_DISP_WIDTH))
                      && (v_cnt >= VW'(V_DISP_START))
                      && (v_cnt <  VW'(VBL_ROW));

endmodule

// File: rtl/reg_port.sv
module reg_port
    import scanline_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  irq_vec_t            status,
    output ctrl_t               ctrl,
    output logic [RASTER_W-1:0] ras_cmp,
    output logic [SCROLL_W-1:0] fwd_vscroll,
    output logic [SCROLL_W-1:0] fwd_hscroll,
    output layer_t              fwd_layer,
    output logic                status_clr,
    output logic [DATA_W-1:0]   rdata
);

    reg_sel_e            sel;
    logic [3:0]          wr_hit;
    logic [SCROLL_W-1:0] vs_q;
    logic [SCROLL_W-1:0] hs_q;
    ctrl_t               wr_ctrl;
    logic                unused_wdata_hi;

    assign sel     = reg_sel_e'(addr);
    assign wr_ctrl = ctrl_t'(wdata[3:0]);
    assign unused_wdata_hi = ^wdata[DATA_W-1:SCROLL_W];

    for (genvar gi = 0; gi < 4; gi++) begin : g_dec
        assign wr_hit[gi] = wr_en && (addr == 2'(gi));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            ras_cmp <= '0;
            vs_q    <= '0;
            hs_q    <= '0;
        end else begin
            if (wr_hit[SEL_CTRL])    ctrl    <= wr_ctrl;
            if (wr_hit[SEL_RASTER])  ras_cmp <= wdata[RASTER_W-1:0];
            if (wr_hit[SEL_VSCROLL]) vs_q    <= wdata[SCROLL_W-1:0];
            if (wr_hit[SEL_HSCROLL]) hs_q    <= wdata[SCROLL_W-1:0];
        end
    end

    // Same-cycle write data goes past the register so a strobe in this cycle sees it.
    assign fwd_vscroll = wr_hit[SEL_VSCROLL] ? wdata[SCROLL_W-1:0] : vs_q;
    assign fwd_hscroll = wr_hit[SEL_HSCROLL] ? wdata[SCROLL_W-1:0] : hs_q;
    assign fwd_layer   = wr_hit[SEL_CTRL] ? layer_t'({wr_ctrl.spr_en, wr_ctrl.bg_en})
                                          : layer_t'({ctrl.spr_en, ctrl.bg_en});

    assign status_clr = rd_en && (sel == SEL_CTRL);

    always_comb begin
        unique case (sel)
            SEL_CTRL:    rdata = {{(DATA_W-NUM_SRC){1'b0}}, status};
            SEL_RASTER:  rdata = {{(DATA_W-RASTER_W){1'b0}}, ras_cmp};
            SEL_VSCROLL: rdata = {{(DATA_W-SCROLL_W){1'b0}}, vs_q};
            default:     rdata = {{(DATA_W-SCROLL_W){1'b0}}, hs_q};
        endcase
    end

endmodule

// File: rtl/scroll_shadow.sv
module scroll_shadow
    import scanline_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  strobe_t             strobe,
    input  logic [SCROLL_W-1:0] fwd_vscroll,
    input  logic [SCROLL_W-1:0] fwd_hscroll,
    input  layer_t              fwd_layer,
    output logic [SCROLL_W-1:0] vscroll_sh,
    output logic [SCROLL_W-1:0] hscroll_sh,
    output layer_t              layer_sh
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vscroll_sh <= '0;
            hscroll_sh <= '0;
            layer_sh   <= '0;
        end else begin
            if (strobe.vscroll) vscroll_sh <= fwd_vscroll;
            if (strobe.hscroll) hscroll_sh <= fwd_hscroll;
            if (strobe.ctrl)    layer_sh   <= fwd_layer;
        end
    end

endmodule

// File: rtl/raster_irq.sv
module raster_irq
    import scanline_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                line_start,
    input  logic                vbl_line,
    input  logic [RASTER_W-1:0] ras_next,
    input  ctrl_t               ctrl,
    input  logic [RASTER_W-1:0] ras_cmp,
    input  logic                clr,
    output irq_vec_t            flags,
    output logic                irq
);

    irq_vec_t           src;
    logic [NUM_SRC-1:0] flag_q;

    assign src.ras = line_start && ctrl.ras_irq_en && (ras_next == ras_cmp);
    assign src.vbl = line_start && ctrl.vbl_irq_en && vbl_line;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[gi] <= 1'b0;
            else     flag_q[gi] <= (flag_q[gi] && !clr) || src[gi];
        end
    end

    assign flags = irq_vec_t'(flag_q);
    assign irq   = |flag_q;

endmodule

// File: rtl/scanline_unit.sv
module scanline_unit
    import scanline_pkg::*;
#(
    parameter int H_TOTAL      = 80,
    parameter int H_DISP_START = 40,
    parameter int H_DISP_WIDTH = 32,
    parameter int V_TOTAL      = 12,
    parameter int V_DISP_START = 2,
    parameter int V_DISP_LINES = 8,
    parameter int PIPE_DEPTH   = 16,
    localparam int HW          = $clog2(H_TOTAL),
    localparam int VW          = $clog2(V_TOTAL)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq,
    output logic [HW-1:0]       h_pos,
    output logic [VW-1:0]       v_pos,
    output logic                disp_active,
    output logic [SCROLL_W-1:0] vscroll_sh,
    output logic [SCROLL_W-1:0] hscroll_sh,
    output logic                bg_en_sh,
    output logic                spr_en_sh
);

    logic                line_start;
    logic                vbl_line;
    logic [RASTER_W-1:0] ras_next;
    strobe_t             strobe;
    ctrl_t               ctrl;
    logic [RASTER_W-1:0] ras_cmp;
    logic [SCROLL_W-1:0] fwd_vscroll;
    logic [SCROLL_W-1:0] fwd_hscroll;
    layer_t              fwd_layer;
    layer_t              layer_sh;
    logic                status_clr;
    irq_vec_t            flags;

    scan_counter #(
        .H_TOTAL(H_TOTAL), .H_DISP_START(H_DISP_START), .H_DISP_WIDTH(H_DISP_WIDTH),
        .V_TOTAL(V_TOTAL), .V_DISP_START(V_DISP_START), .V_DISP_LINES(V_DISP_LINES),
        .PIPE_DEPTH(PIPE_DEPTH), .HW(HW), .VW(VW)
    ) u_cnt (
        .clk(clk), .rst(rst), .h_cnt(h_pos), .v_cnt(v_pos),
        .line_start(line_start), .vbl_line(vbl_line), .disp_active(disp_active),
        .ras_next(ras_next), .strobe(strobe)
    );

    reg_port u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .status(flags), .ctrl(ctrl), .ras_cmp(ras_cmp),
        .fwd_vscroll(fwd_vscroll), .fwd_hscroll(fwd_hscroll), .fwd_layer(fwd_layer),
        .status_clr(status_clr), .rdata(rdata)
    );

    scroll_shadow u_shadow (
        .clk(clk), .rst(rst), .strobe(strobe),
        .fwd_vscroll(fwd_vscroll), .fwd_hscroll(fwd_hscroll), .fwd_layer(fwd_layer),
        .vscroll_sh(vscroll_sh), .hscroll_sh(hscroll_sh), .layer_sh(layer_sh)
    );

    raster_irq u_irq (
        .clk(clk), .rst(rst), .line_start(line_start), .vbl_line(vbl_line),
        .ras_next(ras_next), .ctrl(ctrl), .ras_cmp(ras_cmp), .clr(status_clr),
        .flags(flags), .irq(irq)
    );

    assign bg_en_sh  = layer_sh.bg_en;
    assign spr_en_sh = layer_sh.spr_en;

endmodule

// File: rtl/scanline_unit_chk.sv
module scanline_unit_chk #(
    parameter int H_TOTAL      = 80,
    parameter int H_DISP_START = 40,
    parameter int PIPE_DEPTH   = 16,
    parameter int HW           = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_en,
    input logic [1:0]    addr,
    input logic [HW-1:0] h_pos,
    input logic          irq,
    input logic [9:0]    vscroll_sh,
    input logic [9:0]    hscroll_sh,
    input logic          bg_en_sh,
    input logic          spr_en_sh
);

    localparam int FIRST_COPY = H_DISP_START - PIPE_DEPTH - 6;

    assert_hwrap_R2: assert property (@(posedge clk) disable iff (rst)
        (h_pos == HW'(H_TOTAL - 1)) |=> (h_pos == '0));

    assert_vshadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (h_pos != HW'(FIRST_COPY + 1)) |-> $stable(vscroll_sh));

    assert_hshadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (h_pos != HW'(FIRST_COPY + 2)) |-> $stable(hscroll_sh));

    assert_layer_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (h_pos != HW'(FIRST_COPY + 3)) |-> $stable({bg_en_sh, spr_en_sh}));

    // Both sources fire only at column 0, so a rise is seen at column 1 (R7, R8).
    assert_irq_column_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (h_pos == HW'(1)));

    assert_status_clear_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 2'd0) && (h_pos != '0)) |=> !irq);

endmodule

bind scanline_unit scanline_unit_chk #(
    .H_TOTAL(H_TOTAL), .H_DISP_START(H_DISP_START), .PIPE_DEPTH(PIPE_DEPTH), .HW(HW)
) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .h_pos(h_pos), .irq(irq),
    .vscroll_sh(vscroll_sh), .hscroll_sh(hscroll_sh),
    .bg_en_sh(bg_en_sh), .spr_en_sh(spr_en_sh)
);

// File: tb/tb_scanline_unit.sv
`timescale 1ns/1ps
module tb_scanline_unit;

    localparam int HT = 80, HDS = 40, HDW = 32;
    localparam int VT = 12, VDS = 2, VDL = 8, PIPE = 16;
    localparam int FC = HDS - PIPE - 6;
    localparam int VBL = VDS + VDL;
    localparam int HW = $clog2(HT), VW = $clog2(VT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic irq, disp_active, bg_en_sh, spr_en_sh;
    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic [9:0] vscroll_sh, hscroll_sh;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scanline_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .h_pos(h_pos), .v_pos(v_pos), .disp_active(disp_active),
        .vscroll_sh(vscroll_sh), .hscroll_sh(hscroll_sh),
        .bg_en_sh(bg_en_sh), .spr_en_sh(spr_en_sh)
    );

    function automatic logic [9:0] raster_of(input int v);
        int nxt;
        nxt = (v == VT - 1) ? 0 : v + 1;
        return 10'(nxt + 64 - VDS);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Counter model driven only by the bench's own inputs.
    int m_h = 0, m_v = 0;
    logic [3:0] m_ctrl = '0;
    logic [9:0] m_ras = '0, m_vs = '0, m_hs = '0, m_vsh = '0, m_hsh = '0;
    logic [1:0] m_lay = '0, m_flag = '0;
    logic ev_r, ev_b, clr;

    always @(posedge clk) begin
        if (rst) begin
            m_h <= 0; m_v <= 0; m_ctrl <= '0; m_ras <= '0; m_vs <= '0; m_hs <= '0;
            m_vsh <= '0; m_hsh <= '0; m_lay <= '0; m_flag <= '0;
        end else begin
            cyc <= cyc + 1;
            ev_r = (m_h == 0) && m_ctrl[2] && (raster_of(m_v) == m_ras);
            ev_b = (m_h == 0) && m_ctrl[3] && (m_v == VBL);
            clr  = rd_en && (addr == 2'd0);
            m_flag <= (clr ? 2'b00 : m_flag) | {ev_b, ev_r};
            if (m_h == FC)     m_vsh <= (wr_en && addr == 2'd2) ? wdata[9:0] : m_vs;
            if (m_h == FC + 1) m_hsh <= (wr_en && addr == 2'd3) ? wdata[9:0] : m_hs;
            if (m_h == FC + 2) m_lay <= (wr_en && addr == 2'd0) ? wdata[1:0] : m_ctrl[1:0];
            if (wr_en) begin
                case (addr)
                    2'd0: m_ctrl <= wdata[3:0];
                    2'd1: m_ras  <= wdata[9:0];
                    2'd2: m_vs   <= wdata[9:0];
                    default: m_hs <= wdata[9:0];
                endcase
            end
            m_h <= (m_h == HT - 1) ? 0 : m_h + 1;
            if (m_h == HT - 1) m_v <= (m_v == VT - 1) ? 0 : m_v + 1;
        end
    end

    // Per-cycle comparison, a quarter period after the falling edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_rd;
            bit exp_da;
            #5;
            exp_da = (m_h >= HDS) && (m_h < HDS + HDW) && (m_v >= VDS) && (m_v < VDS + VDL);
            chk(int'(h_pos) == m_h, "R2 h_pos", h_pos, m_h);
            chk(int'(v_pos) == m_v, "R2 v_pos", v_pos, m_v);
            chk(disp_active == exp_da, "R2 disp_active", disp_active, exp_da);
            chk(vscroll_sh == m_vsh, "R3 vscroll_sh", vscroll_sh, m_vsh);
            chk(hscroll_sh == m_hsh, "R4 hscroll_sh", hscroll_sh, m_hsh);
            chk({spr_en_sh, bg_en_sh} == m_lay, "R5 layer bits", {spr_en_sh, bg_en_sh}, m_lay);
            chk(irq == (|m_flag), "R7 R8 R10 irq", irq, |m_flag);
            case (addr)
                2'd0: exp_rd = m_flag;
                2'd1: exp_rd = m_ras;
                2'd2: exp_rd = m_vs;
                default: exp_rd = m_hs;
            endcase
            chk(int'(rdata) == exp_rd, (addr == 2'd0) ? "R11 status" : "R13 readback", rdata, exp_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd_status();
        rd_en = 1'b1; addr = 2'd0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_pos(input int h, input int v);
        do @(negedge clk); while (!(m_h == h && (v < 0 || m_v == v)));
    endtask

    task automatic wait_irq(output bit got);
        got = 1'b0;
        for (int i = 0; i < 3 * HT * VT && !got; i++) begin
            @(negedge clk);
            if (irq) got = 1'b1;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        done = 1'b1;
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        bit got;
        int c0, lv;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk(h_pos == 0 && v_pos == 0, "R1 counters", {v_pos, h_pos}, 0);
        chk(vscroll_sh == 0 && hscroll_sh == 0, "R1 scroll shadows", {vscroll_sh, hscroll_sh}, 0);
        chk(!bg_en_sh && !spr_en_sh, "R1 layer shadows", {spr_en_sh, bg_en_sh}, 0);
        chk(!irq && rdata == 0, "R1 irq/status", {irq, rdata}, 0);
        rst = 1'b0;

        wr(2'd0, 16'h000F);
        wr(2'd1, 16'(raster_of(4)));
        wr(2'd2, 16'h0123);
        wr(2'd3, 16'h02A5);

        // R6: writes that land exactly on each copy strobe
        wait_pos(FC, 3);
        wr_en = 1'b1; addr = 2'd2; wdata = 16'h0155;
        @(negedge clk); #1;
        chk(vscroll_sh == 10'h155, "R6 vscroll same-cycle", vscroll_sh, 10'h155);
        addr = 2'd3; wdata = 16'h00AA;
        @(negedge clk); #1;
        chk(hscroll_sh == 10'h0AA, "R6 hscroll same-cycle", hscroll_sh, 10'h0AA);
        addr = 2'd0; wdata = 16'h000E;
        @(negedge clk); #1;
        chk({spr_en_sh, bg_en_sh} == 2'b10, "R6 layer same-cycle", {spr_en_sh, bg_en_sh}, 2);
        wr_en = 1'b0;

        // R12: fixed gap from raster flag to the matching line's vertical copy
        wr(2'd0, 16'h0007);
        wait_pos(5, -1);
        rd_status();
        wait_irq(got);
        c0 = cyc; lv = v_pos;
        chk(got && lv == 4, "R12 irq line", lv, 4);
        wait_pos(FC + 2, lv);
        wr(2'd2, 16'h03C3);
        for (int i = 0; i < 2 * HT && vscroll_sh != 10'h3C3; i++) @(negedge clk);
        chk(cyc - c0 == HT + FC, "R12 irq-to-copy cycles", cyc - c0, HT + FC);

        // R11: a status read that coincides with a raster event keeps the event
        wr(2'd1, 16'(raster_of(6)));
        wait_pos(5, -1);
        rd_status();
        wait_pos(0, 6);
        rd_en = 1'b1; addr = 2'd0;
        @(negedge clk);
        rd_en = 1'b0; #1;
        chk(irq == 1'b1, "R11 event kept on read", irq, 1);
        chk(rdata[1:0] == 2'b01, "R11 status bits", rdata[1:0], 1);
        rd_status(); #1;
        chk(irq == 1'b0, "R11 cleared after read", irq, 0);

        // R13: compare register readback
        addr = 2'd1; #1;
        chk(rdata == 16'(raster_of(6)), "R13 compare readback", rdata, raster_of(6));
        addr = 2'd0;

        // R9: both sources disabled for two frames
        wr(2'd0, 16'h0003);
        wr(2'd1, 16'(raster_of(3)));
        wait_pos(5, -1);
        rd_status();
        got = 1'b0;
        for (int i = 0; i < 2 * HT * VT; i++) begin
            @(negedge clk);
            if (irq) got = 1'b1;
        end
        chk(!got, "R9 irq while disabled", got, 0);
        #1;
        chk(rdata == 16'd0, "R9 status while disabled", rdata, 0);

        // R7: sweep the compare value over every line
        wr(2'd0, 16'h0007);
        for (int ln = 0; ln < VT; ln++) begin
            wr(2'd1, 16'(raster_of(ln)));
            wait_pos(5, -1);
            rd_status();
            wait_irq(got);
            chk(got && v_pos == ln, "R7 raster line", v_pos, ln);
            chk(h_pos == 1, "R7 raster column", h_pos, 1);
        end

        // R8: vertical-blank only
        wr(2'd0, 16'h000B);
        wait_pos(5, -1);
        rd_status();
        wait_irq(got);
        chk(got && v_pos == VBL, "R8 vblank line", v_pos, VBL);
        chk(h_pos == 1, "R8 vblank column", h_pos, 1);
        #1;
        chk(rdata[1:0] == 2'b10, "R8 vblank status bit", rdata[1:0], 2);

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule